// File: doc/BRIEF.md
# Synchronous Linear Burst Read Sequencer

This block is the device-side control of a synchronous burst-read memory port. A host drives chip enable, address valid and output enable (all active low), a start address and a clock. In burst mode, the sequencer captures the start address and steps a word address through a linear burst. The burst wraps inside an aligned group of 4, 8, 16 or 32 words. Each address is looked up in an internal read-only store, and the word, an end-of-burst flag and the drive enables for both are presented on the bus side.

A small configuration register selects burst or asynchronous operation and the burst length. In asynchronous mode no burst takes place: the port returns the word at whatever address is applied. The block handles the rules for abort and restart. Chip enable high ends a burst. A fresh address-valid pulse discards a burst and starts a new one. Output enable only floats the bus while the burst keeps going. Reset stops everything and returns the configuration to asynchronous mode.

Top module: `lin_burst_rd`

## Requirements
- R1: A cycle with `cfg_wr` high loads the mode bit (`cfg_sync`: 1 = burst, 0 = asynchronous) and the length field `cfg_len` (00 = 4 words, 01 = 8, 10 = 16, 11 = 32). The new setting applies from the following clock edge.
- R2: In burst mode, a rising clock edge with `ce_n` and `adv_n` both low captures `addr_in` onto `mem_addr`. The word at that address is on `dq` after the next rising edge.
- R3: At each later edge with `adv_n` high, the address steps by one inside the aligned group of the selected length. It wraps from the group's top to its base, so a 4-word burst starting at 0x37 reads 0x37, 0x34, 0x35, 0x36. Bits above the group stay fixed.
- R4: `eob` is high exactly while the last word of the burst sequence is on `dq`, and low for every earlier word.
- R5: After the last word, the final word and `eob` stay on the bus until chip enable goes high or a new start arrives.
- R6: Raising `ce_n` drops `dq_oe` and `eob_oe` in the same cycle and ends the burst. Lowering `ce_n` again without an address-valid start leaves the bus floated.
- R7: Address valid low on a clock edge during a burst discards the burst and captures the new address. While `adv_n` is held low, the address does not advance. The new burst advances from the first edge with `adv_n` high.
- R8: `oe_n` high floats `dq` and `eob` at once, while the burst keeps advancing. When `oe_n` returns low, the word due at that point in the sequence is driven.
- R9: `rst` high floats `dq` and `eob` in the same cycle, stops the burst, and at the clock edge returns the configuration to asynchronous mode.
- R10: In asynchronous mode, `mem_addr` follows `addr_in` at every edge while `ce_n` is low, and `dq` carries the word one edge later. `eob` stays low, and `adv_n` never starts a burst.
- R11: The store returns `{~a, a}` for address `a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; floats outputs at once |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_sync | input | 1 | Mode to load: 1 burst, 0 asynchronous |
| cfg_len | input | 2 | Burst length code to load |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | AW | Start / access address |
| mem_addr | output | AW | Read address to the store |
| dq | output | 2*AW | Read data |
| dq_oe | output | 1 | Drive enable for `dq` |
| eob | output | 1 | End-of-burst indicator |
| eob_oe | output | 1 | Drive enable for `eob` |

## Verification
The start edge updates `mem_addr`, and the matching word and `eob` appear one edge later, because the store and the flag stages each add one register. Each burst word is therefore sampled at the falling edge after the following rising edge. The float controls of R6, R8 and R9 act within the cycle, so the bench checks them one time step after it drives `ce_n`, `oe_n` or `rst`, before any clock edge. For the hold, restart and asynchronous cases, the bench counts edges from the stimulus in the same way and samples only at falling edges.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int unsigned CNT_W = 5;

  // index of the final word for a length code
  function automatic logic [CNT_W-1:0] last_idx(input logic [1:0] len);
    case (len)
      2'd0:    return 5'd3;
      2'd1:    return 5'd7;
      2'd2:    return 5'd15;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/lbr_cfg.sv
module lbr_cfg (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic       cfg_sync,
  input  logic [1:0] cfg_len,
  output logic       sync_mode,
  output logic [1:0] len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_mode <= 1'b0;
      len       <= 2'd0;
    end else if (cfg_wr) begin
      sync_mode <= cfg_sync;
      len       <= cfg_len;
    end
  end

  // R1
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (sync_mode == $past(cfg_sync)) && (len == $past(cfg_len)));
endmodule

// File: rtl/lbr_seq.sv
module lbr_seq
  import lbr_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  input  logic          sync_mode,
  input  logic [1:0]    len,
  output logic [AW-1:0] cur_addr,
  output logic          active,
  output logic          at_last
);
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    grp_mask;
  logic [AW-1:0]    step_addr;
  logic             done;

  assign grp_mask  = AW'(last_idx(len));
  assign step_addr = (cur_addr & ~grp_mask) | ((cur_addr + AW'(1)) & grp_mask);
  assign done      = (cnt == last_idx(len));
  assign at_last   = active & sync_mode & done;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      cur_addr <= '0;
    end else if (ce_n) begin
      active <= 1'b0;
    end else if (!sync_mode || !adv_n) begin
      cur_addr <= addr_in;
      cnt      <= '0;
      active   <= 1'b1;
    end else if (active && !done) begin
      cur_addr <= step_addr;
      cnt      <= cnt + CNT_W'(1);
    end
  end

  // R7
  restart_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !adv_n && sync_mode) |=> (cur_addr == $past(addr_in)) && (cnt == '0) && active);

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (active && sync_mode && !ce_n && adv_n)
      |=> ((cur_addr & ~$past(grp_mask)) == ($past(cur_addr) & ~$past(grp_mask))));

  // R5
  hold_last_chk: assert property (@(posedge clk) disable iff (rst)
    (at_last && !ce_n && adv_n) |=> $stable(cur_addr) && active);

  // R6
  ce_abort_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !active);
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
  parameter int unsigned AW = 8
) (
  input  logic            clk,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*AW-1:0] rd_data
);
  localparam int unsigned DW    = 2 * AW;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = {~AW'(g), AW'(g)};
  end

  always_ff @(posedge clk) rd_data <= rom[rd_addr];
endmodule

// File: rtl/lin_burst_rd.sv
module lin_burst_rd #(
  parameter int unsigned AW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_sync,
  input  logic [1:0]      cfg_len,
  input  logic            ce_n,
  input  logic            adv_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr_in,
  output logic [AW-1:0]   mem_addr,
  output logic [2*AW-1:0] dq,
  output logic            dq_oe,
  output logic            eob,
  output logic            eob_oe
);
  logic       sync_mode;
  logic [1:0] len;
  logic       active;
  logic       at_last;
  logic       d_v;
  logic       d_last;
  logic       drive;

  lbr_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sync(cfg_sync),
    .cfg_len(cfg_len), .sync_mode(sync_mode), .len(len)
  );

  lbr_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in),
    .sync_mode(sync_mode), .len(len), .cur_addr(mem_addr),
    .active(active), .at_last(at_last)
  );

  lbr_store #(.AW(AW)) u_store (
    .clk(clk), .rd_addr(mem_addr), .rd_data(dq)
  );

  // flag stage aligned with the registered store read
  always_ff @(posedge clk) begin
    if (rst) begin
      d_v    <= 1'b0;
      d_last <= 1'b0;
    end else begin
      d_v    <= active & ~ce_n;
      d_last <= at_last & ~ce_n;
    end
  end

  // float controls act within the cycle
  assign drive  = d_v & ~ce_n & ~oe_n & ~rst;
  assign dq_oe  = drive;
  assign eob_oe = drive;
  assign eob    = d_last;
endmodule

// File: tb/lin_burst_rd_bench.sv
module lin_burst_rd_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_sync = 1'b0;
  logic [1:0]  cfg_len = 2'd0;
  logic        ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
  logic [7:0]  addr_in = 8'h00;
  logic [7:0]  mem_addr;
  logic [15:0] dq;
  logic        dq_oe, eob, eob_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lin_burst_rd #(.AW(8)) u_lin_burst_rd (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sync(cfg_sync), .cfg_len(cfg_len),
    .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n), .addr_in(addr_in),
    .mem_addr(mem_addr), .dq(dq), .dq_oe(dq_oe), .eob(eob), .eob_oe(eob_oe)
  );

  // {length code, start address}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h00}, {2'd0, 8'h37}, {2'd1, 8'h5A},
    {2'd2, 8'hC3}, {2'd3, 8'h9E}, {2'd2, 8'h0F}
  };

  function automatic logic [15:0] word_of(input logic [7:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic s, input logic [1:0] l);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sync = s; cfg_len = l;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_burst(input logic [1:0] l, input logic [7:0] a);
    int n;
    logic [7:0] m, e;
    n = 4 << l;
    m = 8'(n - 1);
    set_cfg(1'b1, l);
    ce_n = 1'b0; adv_n = 1'b0; addr_in = a;
    @(posedge clk);
    @(negedge clk);
    adv_n = 1'b1;
    chk(mem_addr == a, "R2 start capture", mem_addr, a);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      e = (a & ~m) | (8'(a + i) & m);
      chk(dq == word_of(e) && dq_oe, "R3 R11 wrap word", dq, word_of(e));
      chk(eob == (i == n - 1), "R4 end of burst", eob, (i == n - 1));
    end
    for (int h = 0; h < 2; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk(eob && eob_oe && dq == word_of(e), "R5 hold last", dq, word_of(e));
    end
    ce_n = 1'b1;
    #1;
    chk(!dq_oe && !eob_oe, "R6 float on ce", dq_oe, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!dq_oe && !eob_oe && mem_addr == 8'h00, "R9 reset state", mem_addr, 0);
    rst = 1'b0;

    foreach (VEC[k]) run_burst(VEC[k][9:8], VEC[k][7:0]);

    // R6: no resumption without a new start
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!dq_oe, "R6 no resume", dq_oe, 0);

    // R8: output enable floats, burst advances
    set_cfg(1'b1, 2'd2);
    ce_n = 1'b0; adv_n = 1'b0; addr_in = 8'h20;
    @(posedge clk); @(negedge clk);
    adv_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(dq == word_of(8'h20), "R8 first word", dq, word_of(8'h20));
    oe_n = 1'b1;
    #1;
    chk(!dq_oe && !eob_oe, "R8 float on oe", dq_oe, 0);
    @(posedge clk); @(negedge clk);
    chk(!dq_oe, "R8 still floated", dq_oe, 0);
    @(posedge clk); @(negedge clk);
    oe_n = 1'b0;
    #1;
    chk(dq_oe && dq == word_of(8'h22), "R8 burst advanced", dq, word_of(8'h22));

    // R7: fresh address valid discards burst, held low does not advance
    adv_n = 1'b0; addr_in = 8'h47;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(mem_addr == 8'h47 && dq == word_of(8'h47), "R7 restart held", mem_addr, 8'h47);
    adv_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(dq == word_of(8'h47), "R7 new first word", dq, word_of(8'h47));
    @(posedge clk); @(negedge clk);
    chk(dq == word_of(8'h48) && !eob, "R7 new second word", dq, word_of(8'h48));

    // R9: reset mid burst
    rst = 1'b1;
    #1;
    chk(!dq_oe && !eob_oe, "R9 float on reset", dq_oe, 0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;

    // R10: asynchronous mode after reset
    ce_n = 1'b0; adv_n = 1'b0; addr_in = 8'h12;
    @(posedge clk); @(negedge clk);
    chk(mem_addr == 8'h12, "R10 address follows", mem_addr, 8'h12);
    adv_n = 1'b1; addr_in = 8'h13;
    @(posedge clk); @(negedge clk);
    chk(dq == word_of(8'h12) && dq_oe && !eob, "R10 async word", dq, word_of(8'h12));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_addr == 8'h13 && dq == word_of(8'h13) && !eob, "R10 R1 no burst", mem_addr, 8'h13);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule